// File: doc/BRIEF.md
# Paging-Structure Cache Lookup Unit

This unit sits in front of a four-level page walker that resolves 48-bit virtual addresses. It holds three small caches of upper-level translation entries. The shallowest cache holds top-level entries and is tagged by the top 9 address bits. The middle cache holds third-level entries and is tagged by the top 18 bits. The deepest cache holds directory entries and is tagged by the top 27 bits. A lookup probes all three at once. The deepest hit tells the walker which table base to read next and at which level to resume, and this skips one, two or three table reads. When nothing hits, the walk starts again from the root base.

Each cached entry already carries permissions combined along the path that reached it. Write and user rights are the AND over all levels walked, and execute-disable is the OR. The cache-disable and write-through bits are the entry's own values and are not combined. The walker fills one level at a time. It supplies the entry's own flags and the flags accumulated above it, and the unit merges the two when it stores the entry. A flush empties every cache in one cycle.

Top module: `psc_lookup`

## Requirements
- R1: After reset `res_vld` is 0 and all three caches are empty, so the first lookup returns resume level 4.
- R2: A lookup presented with `lk_vld` high produces its result, with `res_vld` high, on the next clock edge. In a cycle without a lookup, `res_vld` is 0 and the other result outputs keep their last values.
- R3: The shallow cache matches VA[47:39] only, so bits 38:0 do not affect a hit in it.
- R4: The middle cache matches VA[47:30] and the deep cache matches VA[47:21]. Bits below those ranges do not affect a hit.
- R5: The deepest hit wins. A deep-cache hit gives resume level 1, a middle-cache hit gives level 2 and a shallow-cache hit gives level 3. `res_base` is the base stored in the winning entry.
- R6: When no cache hits, `res_base` equals `root_base`, `res_lvl` is 4, write and user are 1, and execute-disable, cache-disable and write-through are 0.
- R7: A stored entry's write flag is `fill_wr & par_wr`, its user flag is `fill_us & par_us`, and its execute-disable flag is `fill_xd | par_xd`. A hit returns these stored values.
- R8: The cache-disable and write-through outputs equal the `fill_pcd` and `fill_pwt` of the winning entry, whatever the parent flags are.
- R9: `fill_lvl` selects the target cache: 1 is shallow, 2 is middle, 3 is deep. Value 0 writes nothing, and a fill never touches another level.
- R10: Each cache has 4 fully associative entries that are replaced round-robin, and the pointer restarts at entry 0 after a flush. The fifth distinct fill after a flush evicts the first.
- R11: A fill whose tag is already present overwrites that entry in place. It neither evicts another entry nor advances the round-robin pointer.
- R12: `flush` invalidates all three caches in one cycle. A fill in the same cycle as the flush is dropped.
- R13: A lookup in the same cycle as a fill sees the contents from before the fill. The new entry can be hit from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all cached entries |
| root_base | input | BASE_W | Root table base, used on a total miss |
| lk_vld | input | 1 | Lookup request |
| lk_va | input | 48 | Lookup virtual address |
| fill_en | input | 1 | Fill request from the walker |
| fill_lvl | input | 2 | Target cache: 1 shallow, 2 middle, 3 deep, 0 none |
| fill_va | input | 48 | Virtual address whose upper bits form the fill tag |
| fill_base | input | BASE_W | Next table base held by the filled entry |
| fill_wr | input | 1 | Entry's own write flag |
| fill_us | input | 1 | Entry's own user flag |
| fill_xd | input | 1 | Entry's own execute-disable flag |
| fill_pcd | input | 1 | Entry's cache-disable bit |
| fill_pwt | input | 1 | Entry's write-through bit |
| par_wr | input | 1 | Write right accumulated above this entry |
| par_us | input | 1 | User right accumulated above this entry |
| par_xd | input | 1 | Execute-disable accumulated above this entry |
| res_vld | output | 1 | Result valid |
| res_lvl | output | 3 | Walk level at which to resume (1 to 4) |
| res_base | output | BASE_W | Table base to read next |
| res_wr | output | 1 | Combined write right |
| res_us | output | 1 | Combined user right |
| res_xd | output | 1 | Combined execute-disable |
| res_pcd | output | 1 | Cache-disable bit of the winning entry |
| res_pwt | output | 1 | Write-through bit of the winning entry |

## Verification
A lookup result is registered on the first clock edge after `lk_vld` is sampled. A fill or flush changes what lookups see from the edge that captures it, so the earliest lookup that can observe it is sampled one edge later. The bench drives every input on the falling edge and holds it for one full cycle. It reads results at the next falling edge, half a cycle after the edge that registered them. For the same-cycle fill and lookup case, it checks the stale result at that point and then issues a second lookup to see the new entry.

// File: rtl/psc_lookup.sv
module psc_lookup #(
  parameter int WAYS   = 4,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int PA_W   = 52,
  localparam int VA_W   = OFF_W + 4 * IDX_W,
  localparam int BASE_W = PA_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [BASE_W-1:0] root_base,
  input  logic              lk_vld,
  input  logic [VA_W-1:0]   lk_va,
  input  logic              fill_en,
  input  logic [1:0]        fill_lvl,
  input  logic [VA_W-1:0]   fill_va,
  input  logic [BASE_W-1:0] fill_base,
  input  logic              fill_wr,
  input  logic              fill_us,
  input  logic              fill_xd,
  input  logic              fill_pcd,
  input  logic              fill_pwt,
  input  logic              par_wr,
  input  logic              par_us,
  input  logic              par_xd,
  output logic              res_vld,
  output logic [2:0]        res_lvl,
  output logic [BASE_W-1:0] res_base,
  output logic              res_wr,
  output logic              res_us,
  output logic              res_xd,
  output logic              res_pcd,
  output logic              res_pwt
);
  localparam int PW = $clog2(WAYS);

  logic [2:0]        lv_hit;
  logic [BASE_W-1:0] lv_base [3];
  logic [4:0]        lv_flg  [3];

  wire [4:0] fill_flg = {fill_wr & par_wr, fill_us & par_us, fill_xd | par_xd,
                         fill_pcd, fill_pwt};

  for (genvar g = 0; g < 3; g++) begin : g_lvl
    localparam int TW = IDX_W * (g + 1);

    logic [TW-1:0]     tag_q  [WAYS];
    logic [BASE_W-1:0] base_q [WAYS];
    logic [4:0]        flg_q  [WAYS];
    logic [WAYS-1:0]   vld_q, lk_m, fl_m;
    logic [PW-1:0]     rr_q, lk_i, fl_i;

    wire [TW-1:0] lk_tag = lk_va[VA_W-1 -: TW];
    wire [TW-1:0] fl_tag = fill_va[VA_W-1 -: TW];
    wire          wr_en  = fill_en && !flush && (fill_lvl == 2'(g + 1));

    always_comb begin
      lk_i = '0;
      fl_i = rr_q;
      for (int w = WAYS - 1; w >= 0; w--) begin
        lk_m[w] = vld_q[w] && (tag_q[w] == lk_tag);
        fl_m[w] = vld_q[w] && (tag_q[w] == fl_tag);
        if (lk_m[w]) lk_i = PW'(w);
        if (fl_m[w]) fl_i = PW'(w);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= '0;
        rr_q  <= '0;
      end else if (flush) begin
        vld_q <= '0;
        rr_q  <= '0;
      end else if (wr_en) begin
        vld_q[fl_i] <= 1'b1;
        if (!(|fl_m))
          rr_q <= (rr_q == PW'(WAYS - 1)) ? '0 : rr_q + 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en) begin
        tag_q[fl_i]  <= fl_tag;
        base_q[fl_i] <= fill_base;
        flg_q[fl_i]  <= fill_flg;
      end
    end

    assign lv_hit[g]  = |lk_m;
    assign lv_base[g] = base_q[lk_i];
    assign lv_flg[g]  = flg_q[lk_i];
  end

  logic [2:0]        sel_lvl;
  logic [BASE_W-1:0] sel_base;
  logic [4:0]        sel_flg;

  always_comb begin
    if (lv_hit[2]) begin
      sel_lvl = 3'd1; sel_base = lv_base[2]; sel_flg = lv_flg[2];
    end else if (lv_hit[1]) begin
      sel_lvl = 3'd2; sel_base = lv_base[1]; sel_flg = lv_flg[1];
    end else if (lv_hit[0]) begin
      sel_lvl = 3'd3; sel_base = lv_base[0]; sel_flg = lv_flg[0];
    end else begin
      sel_lvl = 3'd4; sel_base = root_base; sel_flg = 5'b11000;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld  <= 1'b0;
      res_lvl  <= 3'd4;
      res_base <= '0;
      {res_wr, res_us, res_xd, res_pcd, res_pwt} <= 5'b11000;
    end else begin
      res_vld <= lk_vld;
      if (lk_vld) begin
        res_lvl  <= sel_lvl;
        res_base <= sel_base;
        {res_wr, res_us, res_xd, res_pcd, res_pwt} <= sel_flg;
      end
    end
  end
endmodule

// File: rtl/psc_lookup_chk.sv
module psc_lookup_chk #(
  parameter int BASE_W = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              lk_vld,
  input logic [BASE_W-1:0] root_base,
  input logic              res_vld,
  input logic [2:0]        res_lvl,
  input logic [BASE_W-1:0] res_base,
  input logic              res_wr,
  input logic              res_us,
  input logic              res_xd
);
  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> res_vld == $past(lk_vld));

  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(lk_vld) |-> $stable(res_base) && $stable(res_lvl));

  // R5
  lvl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> res_lvl >= 3'd1 && res_lvl <= 3'd4);

  // R6
  root_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(lk_vld) && res_lvl == 3'd4 |->
      res_base == $past(root_base) && res_wr && res_us && !res_xd);

  // R12
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n, 2) && $past(flush, 2) && $past(lk_vld) |-> res_lvl == 3'd4);
endmodule

bind psc_lookup psc_lookup_chk #(.BASE_W(BASE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .lk_vld(lk_vld),
  .root_base(root_base), .res_vld(res_vld), .res_lvl(res_lvl),
  .res_base(res_base), .res_wr(res_wr), .res_us(res_us), .res_xd(res_xd)
);

// File: tb/psc_lookup_bench.sv
module psc_lookup_bench;
  localparam int BW = 40;
  localparam logic [BW-1:0] ROOT = 40'h000000F00D;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic lk_vld = 1'b0, fill_en = 1'b0;
  logic [47:0] lk_va = '0, fill_va = '0;
  logic [1:0]  fill_lvl = '0;
  logic [BW-1:0] fill_base = '0;
  logic fill_wr = 0, fill_us = 0, fill_xd = 0, fill_pcd = 0, fill_pwt = 0;
  logic par_wr = 0, par_us = 0, par_xd = 0;
  logic res_vld, res_wr, res_us, res_xd, res_pcd, res_pwt;
  logic [2:0] res_lvl;
  logic [BW-1:0] res_base;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  always #4 clk = ~clk;

  psc_lookup u_psc_lookup (
    .clk(clk), .rst_n(rst_n), .flush(flush), .root_base(ROOT),
    .lk_vld(lk_vld), .lk_va(lk_va), .fill_en(fill_en), .fill_lvl(fill_lvl),
    .fill_va(fill_va), .fill_base(fill_base), .fill_wr(fill_wr), .fill_us(fill_us),
    .fill_xd(fill_xd), .fill_pcd(fill_pcd), .fill_pwt(fill_pwt),
    .par_wr(par_wr), .par_us(par_us), .par_xd(par_xd),
    .res_vld(res_vld), .res_lvl(res_lvl), .res_base(res_base), .res_wr(res_wr),
    .res_us(res_us), .res_xd(res_xd), .res_pcd(res_pcd), .res_pwt(res_pwt));

  // {va, expected level, expected base}; entries filled below
  localparam logic [90:0] VEC [8] = '{
    {9'h0A5, 9'h033, 9'h1C7, 9'h000, 12'h000, 3'd1, 40'h3333},
    {9'h0A5, 9'h033, 9'h1C7, 9'h1FF, 12'hFFF, 3'd1, 40'h3333},
    {9'h0A5, 9'h033, 9'h1C6, 9'h000, 12'h000, 3'd2, 40'h2222},
    {9'h0A5, 9'h032, 9'h1C7, 9'h000, 12'h000, 3'd3, 40'h1111},
    {9'h0A4, 9'h033, 9'h1C7, 9'h000, 12'h000, 3'd4, ROOT},
    {9'h0A5, 9'h033, 9'h0C7, 9'h0AA, 12'h123, 3'd2, 40'h2222},
    {9'h000, 9'h000, 9'h000, 9'h000, 12'h000, 3'd4, ROOT},
    {9'h1A5, 9'h033, 9'h1C7, 9'h000, 12'h000, 3'd4, ROOT}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_fill(input logic [1:0] lvl, input logic [47:0] va, input logic [BW-1:0] b,
                          input logic [7:0] f);
    fill_en = 1'b1; fill_lvl = lvl; fill_va = va; fill_base = b;
    {fill_wr, fill_us, fill_xd, fill_pcd, fill_pwt, par_wr, par_us, par_xd} = f;
  endtask

  task automatic do_fill(input logic [1:0] lvl, input logic [47:0] va, input logic [BW-1:0] b,
                         input logic [7:0] f);
    @(negedge clk); set_fill(lvl, va, b, f);
    @(negedge clk); fill_en = 1'b0;
  endtask

  task automatic do_look(input logic [47:0] va);
    @(negedge clk); lk_vld = 1'b1; lk_va = va;
    @(negedge clk); lk_vld = 1'b0;
  endtask

  task automatic do_flush(input logic with_fill);
    @(negedge clk); flush = 1'b1;
    if (with_fill) set_fill(2'd1, {9'h1EE, 39'h0}, 40'h9999, 8'b11000110);
    @(negedge clk); flush = 1'b0; fill_en = 1'b0;
  endtask

  function automatic logic [47:0] top_va(input logic [8:0] t);
    return {t, 39'h0};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 res_vld in reset", res_vld, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 res_vld after reset", res_vld, 0);
    do_look(VEC[0][90:43]);
    chk("R1 empty lvl", res_lvl, 4);
    chk("R6 miss base", res_base, ROOT);
    chk("R6 miss flags", {res_wr, res_us, res_xd, res_pcd, res_pwt}, 5'b11000);
    chk("R2 res_vld one edge after lookup", res_vld, 1);
    @(negedge clk);
    chk("R2 res_vld idle", res_vld, 0);
    chk("R2 base held", res_base, ROOT);

    // fill bits: {wr,us,xd,pcd,pwt,par_wr,par_us,par_xd}
    do_fill(2'd1, VEC[0][90:43], 40'h1111, 8'b10010_110);
    do_fill(2'd2, VEC[0][90:43], 40'h2222, 8'b01001_101);
    do_fill(2'd3, VEC[0][90:43], 40'h3333, 8'b11011_110);

    for (int i = 0; i < 8; i++) begin
      do_look(VEC[i][90:43]);
      chk($sformatf("R3 R4 R5 vec%0d lvl", i), res_lvl, VEC[i][42:40]);
      chk($sformatf("R5 R6 vec%0d base", i), res_base, VEC[i][39:0]);
    end

    do_look(VEC[0][90:43]);
    chk("R7 R8 deep flags", {res_wr, res_us, res_xd, res_pcd, res_pwt}, 5'b11011);
    do_look(VEC[2][90:43]);
    chk("R7 middle wr&par, us&par, xd|par", {res_wr, res_us, res_xd}, 3'b001);
    chk("R8 middle pcd/pwt own", {res_pcd, res_pwt}, 2'b01);
    do_look(VEC[3][90:43]);
    chk("R7 R8 shallow flags", {res_wr, res_us, res_xd, res_pcd, res_pwt}, 5'b10010);

    // R9: level 0 writes nothing; deep fill leaves shallow empty
    do_fill(2'd0, top_va(9'h010), 40'h4444, 8'hFF);
    do_look(top_va(9'h010));
    chk("R9 lvl0 ignored", res_lvl, 4);
    do_fill(2'd3, {9'h011, 9'h005, 9'h006, 21'h0}, 40'h4545, 8'b11000110);
    do_look({9'h011, 9'h005, 9'h006, 21'h1ABCD});
    chk("R9 deep-only hit", res_lvl, 1);
    do_look({9'h011, 9'h004, 9'h006, 21'h0});
    chk("R9 other levels untouched", res_lvl, 4);

    // R13: fill and lookup in one cycle
    @(negedge clk);
    set_fill(2'd1, top_va(9'h077), 40'h7777, 8'b11000110);
    lk_vld = 1'b1; lk_va = top_va(9'h077);
    @(negedge clk); lk_vld = 1'b0; fill_en = 1'b0;
    chk("R13 same-cycle lookup sees old", res_lvl, 4);
    do_look(top_va(9'h077));
    chk("R13 next lookup hits", res_lvl, 3);
    chk("R13 base", res_base, 40'h7777);

    // R10: round robin
    do_flush(1'b0);
    for (int i = 0; i < 4; i++) do_fill(2'd1, top_va(9'h100 + 9'(i)), 40'h500 + 40'(i), 8'b11000110);
    for (int i = 0; i < 4; i++) begin
      do_look(top_va(9'h100 + 9'(i)));
      chk($sformatf("R10 way%0d hit", i), res_base, 40'h500 + 40'(i));
    end
    do_fill(2'd1, top_va(9'h104), 40'h504, 8'b11000110);
    do_look(top_va(9'h100));
    chk("R10 oldest evicted", res_lvl, 4);
    do_look(top_va(9'h101));
    chk("R10 second kept", res_base, 40'h501);
    do_look(top_va(9'h104));
    chk("R10 new entry", res_base, 40'h504);

    // R11: refresh in place
    do_flush(1'b0);
    for (int i = 0; i < 4; i++) do_fill(2'd1, top_va(9'h100 + 9'(i)), 40'h500 + 40'(i), 8'b11000110);
    do_fill(2'd1, top_va(9'h101), 40'h5A1, 8'b11000110);
    do_look(top_va(9'h100));
    chk("R11 no eviction on refill", res_base, 40'h500);
    do_look(top_va(9'h101));
    chk("R11 updated base", res_base, 40'h5A1);
    do_fill(2'd1, top_va(9'h104), 40'h504, 8'b11000110);
    do_look(top_va(9'h100));
    chk("R11 pointer not advanced", res_lvl, 4);
    do_look(top_va(9'h102));
    chk("R11 next way kept", res_base, 40'h502);

    // R12: flush with simultaneous fill
    do_fill(2'd3, VEC[0][90:43], 40'h3333, 8'b11011110);
    do_flush(1'b1);
    do_look(VEC[0][90:43]);
    chk("R12 flushed deep", res_lvl, 4);
    do_look(top_va(9'h102));
    chk("R12 flushed shallow", res_lvl, 4);
    do_look(top_va(9'h1EE));
    chk("R12 fill dropped", res_lvl, 4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule